// File: doc/BRIEF.md
# Four-Rail Power Sequencer Controller

This controller drives four active-high rail enables, called A, B, C and D, from a fault-aware state machine. Three inputs feed it: an under-voltage flag, an over-voltage flag and a sequence request. While both voltage flags are low and the request is high, it raises the rails one at a time in the order A, B, C, D. Before each rail comes on there is a delay, and each of the four delays has its own value. When the request drops, it lowers the rails in the order D, C, B, A, using the same delays in reverse.

A voltage flag takes priority over everything else. Any active voltage flag drops every rail in the same cycle and clears the delay timer. Sequencing starts again from the beginning once both flags are low. Each delay is a 16-bit count of prescaled ticks, and one tick is `PRESCALE` clocks long. The delay values are static configuration inputs and change only while the block is idle or settled. The request input is active high. A board that does not use it ties it high, and the rails then follow voltage compliance alone. All three inputs are asynchronous and each passes through two flip-flops before the state machine uses it.

Top module: `pwr_rail_sequencer`

## Requirements
- R1: `rail_en_o` always has thermometer form: bit 0 is rail A, bit 3 is rail D, and a rail is on only if every lower-numbered rail is on. The rail count changes by at most one per clock, except when a fault clears it.
- R2: On the rising sequence, rail A turns on 3 + Dstart·P clocks after the request rises. Each later rail turns on 1 + D·P clocks after the previous one, with D taken as Dab, Dbc and Dcd in turn. P is `PRESCALE`.
- R3: A delay value of zero means the next rail switches on the clock after the previous step, which gives a 1-clock gap.
- R4: No rail turns on while either voltage flag, after synchronization, is active. The first rail only comes after compliance.
- R5: When a voltage flag rises, all four enables drop together on the second clock edge after it and stay low while the flag stays high.
- R6: When both flags return low and the request is high, the full rising sequence runs again from rail A with the timing of R2, measured from when the flag falls.
- R7: When the request falls with all rails on, rail D turns off 3 + Dstart·P clocks later. After that, C, B and A each turn off 1 + Dcd·P, 1 + Dbc·P and 1 + Dab·P clocks after the previous rail.
- R8: If the request changes partway through a sequence, the block reverses from the rails already on. It does not restart, and no further rail in the old direction turns on.
- R9: `fault_o` is the synchronized OR of the two voltage flags, with a latency of two clocks. It reads 1 during reset.
- R10: `seq_done_o` is 1 exactly when all four enables are on. `seq_idle_o` is 1 exactly when all four enables are off.
- R11: During and right after reset, all enables are 0, `fault_o` is 1, `seq_idle_o` is 1 and `seq_done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_flag_i | input | 1 | Under-voltage flag, asynchronous, active high |
| ov_flag_i | input | 1 | Over-voltage flag, asynchronous, active high |
| seq_en_i | input | 1 | Sequence request, high = power up, low = power down |
| dly_start_i | input | 16 | Ticks before the first step in either direction |
| dly_ab_i | input | 16 | Ticks for the gap between rails A and B |
| dly_bc_i | input | 16 | Ticks for the gap between rails B and C |
| dly_cd_i | input | 16 | Ticks for the gap between rails C and D |
| rail_en_o | output | 4 | Rail enables, bit 0 = A through bit 3 = D |
| fault_o | output | 1 | Synchronized voltage fault status |
| seq_done_o | output | 1 | All rails on |
| seq_idle_o | output | 1 | All rails off |

## Verification
A wrong rail count or direction shows up at once as a non-thermometer enable pattern or as a rail switching in the wrong order. A timer that restarts too late or too early moves a rail edge by whole ticks, so the bench measures each edge to the exact clock. A fault that is handled wrongly either leaves rails on after the two-clock synchronizer latency, or makes the next power-up start somewhere other than rail A with the start delay. Both are visible within one step of the flag change.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  localparam int RAILS  = 4;
  localparam int LVL_W  = $clog2(RAILS + 1);
  localparam int GAP_W  = $clog2(RAILS);
  localparam int DLY_W  = 16;

  typedef logic [LVL_W-1:0] level_t;
  typedef logic [GAP_W-1:0] gap_t;
  typedef logic [DLY_W-1:0] dly_t;

  // Gap used for the next step from a given rail count.
  // Rising from L rails uses gap L; falling from L < RAILS uses gap L;
  // falling from all-on uses the start gap.
  function automatic gap_t gap_of(level_t lvl);
    if (lvl == level_t'(RAILS)) return gap_t'(0);
    return gap_t'(lvl);
  endfunction
endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d_i;
      stage2 <= stage1;
    end
  end

  assign q_o = stage2;
endmodule

// File: rtl/pwrseq_gap_timer.sv
module pwrseq_gap_timer #(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] delay_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] ticks;
  logic             tick;
  logic             reached;

  assign reached   = (ticks == delay_i);
  assign expired_o = reached;

  generate
    if (PRESCALE <= 1) begin : g_no_prescale
      assign tick = 1'b1;
    end else begin : g_prescale
      localparam int PRE_W = $clog2(PRESCALE);
      logic [PRE_W-1:0] pre;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              pre <= '0;
        else if (restart_i || reached)           pre <= '0;
        else if (pre == PRE_W'(PRESCALE - 1))    pre <= '0;
        else                                     pre <= pre + 1'b1;
      end
      assign tick = (pre == PRE_W'(PRESCALE - 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ticks <= '0;
    else if (restart_i)         ticks <= '0;
    else if (tick && !reached)  ticks <= ticks + 1'b1;
  end

  // R2: the count never runs past the programmed delay
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(delay_i) && !$past(restart_i)) |-> (ticks <= delay_i));
endmodule

// File: rtl/pwr_rail_sequencer.sv
module pwr_rail_sequencer
  import pwrseq_pkg::*;
#(
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uv_flag_i,
  input  logic             ov_flag_i,
  input  logic             seq_en_i,
  input  logic [DLY_W-1:0] dly_start_i,
  input  logic [DLY_W-1:0] dly_ab_i,
  input  logic [DLY_W-1:0] dly_bc_i,
  input  logic [DLY_W-1:0] dly_cd_i,
  output logic [RAILS-1:0] rail_en_o,
  output logic             fault_o,
  output logic             seq_done_o,
  output logic             seq_idle_o
);
  logic [2:0] sync_q;
  logic       uv_s, ov_s, up_s, fault_s;

  // Flags reset to "fault" so nothing starts before compliance is seen.
  pwrseq_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({uv_flag_i, ov_flag_i, seq_en_i}),
    .q_o   (sync_q)
  );
  assign {uv_s, ov_s, up_s} = sync_q;
  assign fault_s = uv_s | ov_s;

  level_t level, target;
  logic   moving, moving_q, up_q, redirect, step, expired, restart;
  dly_t   gap_dly [RAILS];
  dly_t   cur_dly;

  assign gap_dly[0] = dly_start_i;
  assign gap_dly[1] = dly_ab_i;
  assign gap_dly[2] = dly_bc_i;
  assign gap_dly[3] = dly_cd_i;

  assign target   = up_s ? level_t'(RAILS) : '0;
  assign moving   = !fault_s && (level != target);
  assign redirect = moving && moving_q && (up_s != up_q);
  assign cur_dly  = gap_dly[gap_of(level)];
  assign step     = moving && !redirect && expired;
  assign restart  = fault_s || !moving || step || redirect;

  pwrseq_gap_timer #(.CNT_W(DLY_W), .PRESCALE(PRESCALE)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .delay_i   (cur_dly),
    .expired_o (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level    <= '0;
      moving_q <= 1'b0;
      up_q     <= 1'b0;
    end else begin
      moving_q <= moving;
      up_q     <= up_s;
      if (fault_s)   level <= '0;
      else if (step) level <= up_s ? level + 1'b1 : level - 1'b1;
    end
  end

  logic [RAILS-1:0] rail_mask;
  generate
    for (genvar r = 0; r < RAILS; r++) begin : g_rail
      assign rail_mask[r] = (level > level_t'(r));
    end
  endgenerate

  assign rail_en_o  = rail_mask & {RAILS{~fault_s}};
  assign fault_o    = fault_s;
  assign seq_done_o = &rail_en_o;
  assign seq_idle_o = ~|rail_en_o;

  // R1: enables always form a thermometer code
  assert_thermo_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({1'b0, rail_en_o} + 5'd1) == 1);

  // R1: rail count moves by one unless a fault cleared it
  assert_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fault_s) && level != $past(level)) |->
      (int'(level) == int'($past(level)) + 1 || int'(level) + 1 == int'($past(level))));

  // R4: a first rail only rises after a compliant cycle
  assert_compliant_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en_o[0]) |-> !$past(fault_s));

  // R5: a fault clears the rail count on the next edge
  assert_fault_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_s |=> (level == '0));

  // R7: with the request low, the rail count never grows
  assert_down_when_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(up_s) && !$past(fault_s)) |-> (level <= $past(level)));
endmodule

// File: tb/tb_pwr_rail_sequencer.sv
`timescale 1ns/1ps
module tb_pwr_rail_sequencer;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        uv = 1'b1, ov = 1'b0, seq = 1'b1;
  logic [15:0] d_start = '0, d_ab = '0, d_bc = '0, d_cd = '0;
  logic [3:0]  en;
  logic        fault, done, idle;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pwr_rail_sequencer #(.PRESCALE(P)) dut (
    .clk(clk), .rst_n(rst_n), .uv_flag_i(uv), .ov_flag_i(ov), .seq_en_i(seq),
    .dly_start_i(d_start), .dly_ab_i(d_ab), .dly_bc_i(d_bc), .dly_cd_i(d_cd),
    .rail_en_o(en), .fault_o(fault), .seq_done_o(done), .seq_idle_o(idle)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_delays(input int a, input int b, input int c, input int d);
    d_start = 16'(a); d_ab = 16'(b); d_bc = 16'(c); d_cd = 16'(d);
  endtask

  function automatic bit is_thermo(input logic [3:0] v);
    return v == 4'h0 || v == 4'h1 || v == 4'h3 || v == 4'h7 || v == 4'hF;
  endfunction

  // Expected edge time of each rail in clocks after the driving negedge.
  function automatic int edge_time(input bit up, input int rail);
    int g[4];
    int t;
    g[0] = d_start; g[1] = d_ab; g[2] = d_bc; g[3] = d_cd;
    t = 3 + g[0] * P;
    if (up) begin
      for (int i = 1; i <= rail; i++) t += 1 + g[i] * P;
    end else begin
      for (int i = 3; i > rail; i--) t += 1 + g[i] * P;
    end
    return t;
  endfunction

  // Called right after the input change at a negedge.
  task automatic measure(input bit up, input string req);
    int got[4];
    int lim;
    bit thermo_ok;
    logic [3:0] prev;
    thermo_ok = 1;
    lim = 0;
    for (int r = 0; r < 4; r++) begin
      got[r] = -1;
      if (edge_time(up, r) > lim) lim = edge_time(up, r);
    end
    prev = en;
    for (int c = 1; c <= lim + 5; c++) begin
      @(posedge clk); #1;
      if (!is_thermo(en)) thermo_ok = 0;
      for (int r = 0; r < 4; r++)
        if (en[r] != prev[r] && got[r] < 0) got[r] = c;
      prev = en;
    end
    check(thermo_ok, "R1", "thermometer shape during sequence", 0, 1);
    for (int r = 0; r < 4; r++)
      check(got[r] == edge_time(up, r), req, $sformatf("rail %0d edge time", r),
            got[r], edge_time(up, r));
    if (up) check(en == 4'hF && done && !idle, "R10", "all on status",
                  {done, idle, en}, 6'b10_1111);
    else    check(en == 4'h0 && !done && idle, "R10", "all off status",
                  {done, idle, en}, 6'b01_0000);
  endtask

  task automatic wait_for(input logic [3:0] pattern);
    while (en != pattern) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(20240601);
    set_delays(2, 1, 3, 0);
    repeat (3) @(posedge clk);
    #1;
    check(en == 0 && fault && idle && !done, "R11", "reset outputs",
          {en, fault, idle, done}, 7'b0000_110);
    @(negedge clk); rst_n = 1'b1;

    // R4: under-voltage held with request high keeps rails off
    repeat (40) @(posedge clk);
    #1;
    check(en == 0, "R4", "no rail while non-compliant", en, 0);
    check(fault == 1, "R9", "fault status tracks under-voltage", fault, 1);
    @(negedge clk); uv = 1'b0;
    measure(1, "R4");
    check(fault == 0, "R9", "fault status clear", fault, 0);

    @(negedge clk); seq = 1'b0;
    measure(0, "R7");

    // R3: all-zero delays give one-clock gaps
    set_delays(0, 0, 0, 0);
    @(negedge clk); seq = 1'b1;
    measure(1, "R3");
    @(negedge clk); seq = 1'b0;
    measure(0, "R3");

    // R2: a large gap
    set_delays(1, 300, 0, 2);
    @(negedge clk); seq = 1'b1;
    measure(1, "R2");
    @(negedge clk); seq = 1'b0;
    measure(0, "R7");

    // Random delay sets
    for (int it = 0; it < 12; it++) begin
      set_delays($urandom_range(0, 6), $urandom_range(0, 6),
                 $urandom_range(0, 6), $urandom_range(0, 6));
      @(negedge clk); seq = 1'b1;
      measure(1, "R2");
      @(negedge clk); seq = 1'b0;
      measure(0, "R7");
    end

    // R5/R6: fault partway up, then restart from rail A
    set_delays(3, 3, 3, 3);
    @(negedge clk); seq = 1'b1;
    wait_for(4'h3);
    @(negedge clk); uv = 1'b1;
    @(posedge clk); #1;
    check(en == 4'h3 && fault == 0, "R9", "fault latency first edge",
          {fault, en}, 5'b0_0011);
    @(posedge clk); #1;
    check(en == 4'h0, "R5", "all rails drop together", en, 0);
    check(fault == 1, "R9", "fault status after two edges", fault, 1);
    begin
      bit stayed_low;
      stayed_low = 1;
      repeat (30) begin @(posedge clk); #1; if (en != 0) stayed_low = 0; end
      check(stayed_low, "R5", "rails held low during fault", en, 0);
    end
    @(negedge clk); uv = 1'b0;
    measure(1, "R6");

    // R5: over-voltage after completion
    @(negedge clk); ov = 1'b1;
    @(posedge clk); #1;
    check(en == 4'hF, "R5", "rails before sync latency", en, 15);
    @(posedge clk); #1;
    check(en == 4'h0 && !done && idle, "R5", "over-voltage drops all rails",
          {done, idle, en}, 6'b01_0000);
    @(negedge clk); ov = 1'b0;
    measure(1, "R6");
    @(negedge clk); seq = 1'b0;
    measure(0, "R7");

    // R8: reverse partway up
    set_delays(2, 2, 2, 2);
    @(negedge clk); seq = 1'b1;
    wait_for(4'h3);
    @(negedge clk); seq = 1'b0;
    begin
      bit never_higher;
      bit thermo_ok;
      never_higher = 1;
      thermo_ok = 1;
      repeat (120) begin
        @(posedge clk); #1;
        if (en[2] || en[3]) never_higher = 0;
        if (!is_thermo(en)) thermo_ok = 0;
      end
      check(never_higher, "R8", "no further rail after reversal", en, 3);
      check(thermo_ok, "R8", "reverse order keeps thermometer", 0, 1);
      check(en == 0 && idle, "R8", "reversed sequence ends off", en, 0);
    end

    // R8: reverse partway down, rails come back up without restart
    @(negedge clk); seq = 1'b1;
    measure(1, "R2");
    @(negedge clk); seq = 1'b0;
    wait_for(4'h3);
    @(negedge clk); seq = 1'b1;
    begin
      bit never_lower;
      never_lower = 1;
      repeat (80) begin
        @(posedge clk); #1;
        if (!en[1]) never_lower = 0;
      end
      check(never_lower, "R8", "rail B kept through reversal", en[1], 1);
      check(en == 4'hF && done, "R8", "re-rise completes", en, 15);
    end

    // R9: fault while idle only moves the status
    @(negedge clk); seq = 1'b0;
    measure(0, "R7");
    @(negedge clk); ov = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(fault == 1 && en == 0, "R9", "idle fault status", {fault, en}, 5'b1_0000);
    @(negedge clk); ov = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check(fault == 0 && idle, "R9", "idle fault clear", fault, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule